// File: doc/BRIEF.md
# Pipelined Burst SRAM with Selectable Output Turn-Off

This block is a synthesizable behavioural model of a synchronous pipelined burst SRAM. A small internal array holds words of four byte lanes, each nine bits wide. Address, chip enable, two burst-start strobes, burst advance and the write controls are all captured on the rising clock edge. Writes take effect at that same edge. Read data passes through one registered output stage, so a burst runs with 3-1-1-1 timing. A two-bit burst counter steps through the four words of an aligned group, either in linear order or in interleaved order.

The data bus drive is a separate enable output that a pad buffer uses. The `scd_mode` input decides how quickly the drive stops after a deselect. With `scd_mode` high, the drive stops one stage earlier than read data would appear. With it low, the drive stops with the same latency as a read. Output enable and sleep act on the drive asynchronously. While sleep is high, all commands are refused and the array keeps its contents.

Top module: `burst_sram_pipe`

## Requirements
- R1: A burst start with `chip_en` high captures `addr` at the rising edge, and that edge is the only point where any synchronous input takes effect.
- R2: A read command captured at edge k gives `data_drv` high and `data_q` equal to the word read after edge k+1. This applies when `oe` is high, sleep is low and no early turn-off intervenes.
- R3: The burst address keeps bits above bit 1 fixed at the start address. Each `adv` cycle raises a 2-bit counter n. The low bits are start+n mod 4 when `linear` is 1, and start XOR n when `linear` is 0. A selected cycle with no strobe and no `adv` accesses the same word again.
- R4: A burst started with `load_a` is always a read. All write controls in that cycle are ignored.
- R5: With `gwe` high, a write command writes all four lanes. `bwe` and `byte_wr` have no effect on it.
- R6: With `gwe` low, a write happens only when `bwe` is high and `byte_wr` is non-zero. Lane i (bits 9i+8..9i) is written only when `byte_wr[i]` is 1. With `bwe` low, or with `byte_wr` all zero, the cycle is a read.
- R7: With `scd_mode`=1, a deselect captured at edge k drives `data_drv` low from edge k onward. This cancels the data slot of a read captured at edge k-1. A deselect is either strobe while `chip_en` is low.
- R8: With `scd_mode`=0, a deselect captured at edge k keeps the data slot of the read captured at edge k-1. `data_drv` is low after edge k+1.
- R9: A write command captured at edge k never gives drive: `data_drv` is low after edge k+1.
- R10: While `oe` is low, `data_drv` is low at once, without waiting for a clock edge.
- R11: While `sleep` is high, `data_drv` is low at once and no command is accepted. The array contents stay unchanged, and an open burst is dropped.
- R12: While `rst_n` is low, `data_drv` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address for a burst start |
| chip_en | input | 1 | Selects the block on a burst start; low turns the start into a deselect |
| load_a | input | 1 | Burst start that always reads |
| load_b | input | 1 | Burst start that honours the write controls |
| adv | input | 1 | Steps the burst counter |
| bwe | input | 1 | Enables the per-lane write strobes |
| byte_wr | input | LANES | Per-lane write strobes |
| gwe | input | 1 | Writes all lanes |
| data_in | input | LANES*LANE_W | Write data |
| linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| scd_mode | input | 1 | 1 = early turn-off after deselect, 0 = read-latency turn-off |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep |
| data_q | output | LANES*LANE_W | Registered read data |
| data_drv | output | 1 | Bus drive enable for `data_q` |

## Verification
The key collision is a read's data slot landing in the same cycle as a deselect that was captured one edge later. The bench provokes it by issuing a read and then a deselect back to back, once in each mode. In early turn-off mode the slot must show no drive. In read-latency mode the slot must show drive and the correct word. The bench also puts a read's data slot in the same cycle as a following write command, and expects the read data to be presented unchanged.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } acc_op_e;

   // Low two address bits of a burst beat, from the start bits and the beat count.
   function automatic logic [1:0] burst_step(input logic [1:0] start,
                                             input logic [1:0] count,
                                             input logic       linear);
      logic [1:0] sum;
      sum = start + count;
      return linear ? sum : (start ^ count);
   endfunction

endpackage

// File: rtl/bsram_burst_ctl.sv
module bsram_burst_ctl
   import bsram_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic [ADDR_W-1:0] addr,
   input  logic              chip_en,
   input  logic              load_a,
   input  logic              load_b,
   input  logic              adv,
   input  logic              linear,
   input  logic              wr_req,
   output logic [ADDR_W-1:0] acc_addr,
   output acc_op_e           acc_op,
   output logic              acc_desel
);

   localparam int HI_W = ADDR_W - 2;

   logic              sel_q, sel_d;
   logic [ADDR_W-1:0] base_q, base_d;
   logic [1:0]        cnt_q, cnt_d;
   logic [HI_W-1:0]   hi_bits;

   always_comb begin
      sel_d     = sel_q;
      base_d    = base_q;
      cnt_d     = cnt_q;
      acc_op    = OP_IDLE;
      acc_desel = 1'b0;
      if (sleep) begin
         sel_d = 1'b0;
      end else if (load_a || load_b) begin
         if (!chip_en) begin
            sel_d     = 1'b0;
            acc_desel = 1'b1;
         end else begin
            sel_d  = 1'b1;
            base_d = addr;
            cnt_d  = 2'd0;
            acc_op = (load_b && !load_a && wr_req) ? OP_WRITE : OP_READ;
         end
      end else if (sel_q) begin
         if (adv) begin
            cnt_d = cnt_q + 2'd1;
         end
         acc_op = wr_req ? OP_WRITE : OP_READ;
      end
   end

   assign hi_bits  = base_d[ADDR_W-1:2];
   assign acc_addr = {hi_bits, burst_step(base_d[1:0], cnt_d, linear)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         base_q <= '0;
         cnt_q  <= 2'd0;
      end else begin
         sel_q  <= sel_d;
         base_q <= base_d;
         cnt_q  <= cnt_d;
      end
   end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_mask,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] q;

      always_ff @(posedge clk) begin
         if (wr_en && wr_mask[g]) begin
            mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
         end
         q <= mem[rd_addr];
      end

      assign rd_data[g*LANE_W +: LANE_W] = q;
   end

endmodule

// File: rtl/bsram_out_stage.sv
module bsram_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   input  logic oe,
   input  logic scd_mode,
   input  logic st_read,
   input  logic desel_now,
   output logic drive
);

   logic drv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= 1'b0;
      end else if (sleep) begin
         drv_q <= 1'b0;
      end else if (scd_mode && desel_now) begin
         drv_q <= 1'b0;
      end else begin
         drv_q <= st_read;
      end
   end

   assign drive = drv_q & oe & ~sleep;

endmodule

// File: rtl/burst_sram_pipe.sv
module burst_sram_pipe
   import bsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    chip_en,
   input  logic                    load_a,
   input  logic                    load_b,
   input  logic                    adv,
   input  logic                    bwe,
   input  logic [LANES-1:0]        byte_wr,
   input  logic                    gwe,
   input  logic [LANES*LANE_W-1:0] data_in,
   input  logic                    linear,
   input  logic                    scd_mode,
   input  logic                    oe,
   input  logic                    sleep,
   output logic [LANES*LANE_W-1:0] data_q,
   output logic                    data_drv
);

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("burst_sram_pipe: ADDR_W must be at least 3");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("burst_sram_pipe: LANES and LANE_W must be positive");
   end

   logic              wr_req;
   logic [ADDR_W-1:0] acc_addr;
   acc_op_e           acc_op;
   logic              acc_desel;
   logic [LANES-1:0]  wr_mask;
   logic              st_read_q;
   logic [ADDR_W-1:0] st_addr_q;
   logic [DATA_W-1:0] rd_data;

   assign wr_req  = gwe | (bwe & (|byte_wr));
   assign wr_mask = gwe ? {LANES{1'b1}} : (bwe ? byte_wr : '0);

   bsram_burst_ctl #(.ADDR_W(ADDR_W)) ctl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep    (sleep),
      .addr     (addr),
      .chip_en  (chip_en),
      .load_a   (load_a),
      .load_b   (load_b),
      .adv      (adv),
      .linear   (linear),
      .wr_req   (wr_req),
      .acc_addr (acc_addr),
      .acc_op   (acc_op),
      .acc_desel(acc_desel)
   );

   // Command stage: one register between capture and the array read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_read_q <= 1'b0;
         st_addr_q <= '0;
      end else begin
         st_read_q <= (acc_op == OP_READ);
         st_addr_q <= acc_addr;
      end
   end

   bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
      .clk    (clk),
      .wr_en  (acc_op == OP_WRITE),
      .wr_addr(acc_addr),
      .wr_mask(wr_mask),
      .wr_data(data_in),
      .rd_addr(st_addr_q),
      .rd_data(rd_data)
   );

   bsram_out_stage out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep    (sleep),
      .oe       (oe),
      .scd_mode (scd_mode),
      .st_read  (st_read_q),
      .desel_now(acc_desel),
      .drive    (data_drv)
   );

   assign data_q = rd_data;

endmodule

// File: rtl/bsram_checks.sv
module bsram_checks #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chip_en,
   input logic             load_a,
   input logic             load_b,
   input logic             bwe,
   input logic [LANES-1:0] byte_wr,
   input logic             gwe,
   input logic             scd_mode,
   input logic             oe,
   input logic             sleep,
   input logic             data_drv
);

   logic wreq, desel_in, rd_load, wr_load;

   assign wreq     = gwe | (bwe & (|byte_wr));
   assign desel_in = !sleep && (load_a || load_b) && !chip_en;
   assign rd_load  = !sleep && chip_en && (load_a || (load_b && !wreq));
   assign wr_load  = !sleep && chip_en && load_b && !load_a && wreq;

   // R11: sleep keeps the bus undriven
   a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !data_drv);

   // R10: output enable low keeps the bus undriven
   a_r10_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !data_drv);

   // R7: early turn-off right after the deselect edge
   a_r7_scd_early_off: assert property (@(posedge clk) disable iff (!rst_n)
      (desel_in && scd_mode) |=> !data_drv);

   // R8: turn-off no later than the second edge
   a_r8_desel_off: assert property (@(posedge clk) disable iff (!rst_n)
      desel_in |=> ##1 !data_drv);

   // R9: write slot never drives
   a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load |=> ##1 !data_drv);

   // R2: read slot drives unless cancelled or masked
   a_r2_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load ##1 (!sleep && !(scd_mode && desel_in)) |=> (!oe || sleep || data_drv));

endmodule

bind burst_sram_pipe bsram_checks #(.LANES(LANES)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .chip_en (chip_en),
   .load_a  (load_a),
   .load_b  (load_b),
   .bwe     (bwe),
   .byte_wr (byte_wr),
   .gwe     (gwe),
   .scd_mode(scd_mode),
   .oe      (oe),
   .sleep   (sleep),
   .data_drv(data_drv)
);

// File: tb/burst_sram_pipe_tb_top.sv
module burst_sram_pipe_tb_top;

   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          chip_en = 1'b0;
   logic          load_a = 1'b0;
   logic          load_b = 1'b0;
   logic          adv = 1'b0;
   logic          bwe = 1'b0;
   logic [NL-1:0] byte_wr = '0;
   logic          gwe = 1'b0;
   logic [DW-1:0] data_in = '0;
   logic          linear = 1'b1;
   logic          scd_mode = 1'b0;
   logic          oe = 1'b1;
   logic          sleep = 1'b0;
   logic [DW-1:0] data_q;
   logic          data_drv;

   always #5 clk = ~clk;

   burst_sram_pipe #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .chip_en(chip_en),
      .load_a(load_a), .load_b(load_b), .adv(adv), .bwe(bwe),
      .byte_wr(byte_wr), .gwe(gwe), .data_in(data_in), .linear(linear),
      .scd_mode(scd_mode), .oe(oe), .sleep(sleep),
      .data_q(data_q), .data_drv(data_drv)
   );

   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // reference model state
   logic [DW-1:0] refm [DEPTH];
   logic          m_sel = 1'b0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = 2'd0;
   logic          prev_rd = 1'b0;
   logic [DW-1:0] prev_data = '0;

   function automatic logic [DW-1:0] pat(int a, int s);
      logic [DW-1:0] v;
      v = DW'(a + 1) * DW'(32'h9E37_79B1);
      return v ^ (DW'(s) << 27);
   endfunction

   task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One clock: model the captured command, advance to the next falling edge, compare.
   task automatic step();
      logic          wrq;
      logic [NL-1:0] mask;
      int            op;
      bit            desel;
      logic [1:0]    off;
      logic [AW-1:0] a;
      logic          cur_rd;
      logic [DW-1:0] cur_data;
      logic          exp_drv;
      wrq   = gwe | (bwe & (|byte_wr));
      mask  = gwe ? {NL{1'b1}} : (bwe ? byte_wr : '0);
      op    = 0;
      desel = 1'b0;
      if (sleep) begin
         m_sel = 1'b0;
      end else if (load_a || load_b) begin
         if (!chip_en) begin
            m_sel = 1'b0;
            desel = 1'b1;
         end else begin
            m_sel  = 1'b1;
            m_base = addr;
            m_cnt  = 2'd0;
            op     = (load_b && !load_a && wrq) ? 2 : 1;
         end
      end else if (m_sel) begin
         if (adv) m_cnt = m_cnt + 2'd1;
         op = wrq ? 2 : 1;
      end
      off = linear ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
      a   = {m_base[AW-1:2], off};
      if (op == 2) begin
         for (int l = 0; l < NL; l++)
            if (mask[l]) refm[a][l*LW +: LW] = data_in[l*LW +: LW];
      end
      cur_rd   = (op == 1);
      cur_data = refm[a];
      @(negedge clk);
      exp_drv = !sleep && oe && !(scd_mode && desel) && prev_rd;
      chk(data_drv == exp_drv, cur_req, "drive", DW'(data_drv), DW'(exp_drv));
      if (exp_drv)
         chk(data_q == prev_data, cur_req, "read data", data_q, prev_data);
      prev_rd   = cur_rd;
      prev_data = cur_data;
   endtask

   task automatic ctl_clear();
      load_a = 0; load_b = 0; adv = 0; bwe = 0; byte_wr = '0; gwe = 0; chip_en = 1;
   endtask

   task automatic do_read_start(int a);
      ctl_clear(); load_a = 1; addr = AW'(a); step();
   endtask

   task automatic do_adv(bit w, logic [DW-1:0] d);
      ctl_clear(); adv = 1; gwe = w; data_in = d; step();
   endtask

   task automatic do_write_all(int a, logic [DW-1:0] d);
      ctl_clear(); load_b = 1; gwe = 1; addr = AW'(a); data_in = d; step();
   endtask

   task automatic do_desel();
      ctl_clear(); chip_en = 0; load_a = 1; step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) refm[i] = '0;
      ctl_clear();
      chip_en = 0;
      repeat (3) @(negedge clk);
      chk(data_drv == 1'b0, "R12", "drive in reset", DW'(data_drv), '0);
      rst_n = 1;
      @(negedge clk);
      chk(data_drv == 1'b0, "R12", "drive after reset", DW'(data_drv), '0);

      // Fill every word with global writes (R1, R5)
      cur_req = "R5";
      for (int a = 0; a < DEPTH; a++) begin
         ctl_clear(); load_b = 1; gwe = 1; bwe = 0; byte_wr = '0;
         addr = AW'(a); data_in = pat(a, 0); step();
      end
      do_desel(); do_desel();

      // Every start address, both burst orders, back-to-back beats (R1, R2, R3)
      for (int lin = 0; lin < 2; lin++) begin
         linear = lin[0];
         for (int b = 0; b < DEPTH; b++) begin
            cur_req = "R1";
            do_read_start(b);
            cur_req = "R3";
            for (int k = 0; k < 3; k++) do_adv(1'b0, '0);
         end
         cur_req = "R2";
         do_desel(); do_desel();
      end
      linear = 1;

      // Per-lane strobes for every mask (R6)
      cur_req = "R6";
      for (int m = 0; m < 16; m++) begin
         ctl_clear(); load_b = 1; bwe = 1; byte_wr = NL'(m);
         addr = AW'(5); data_in = pat(m, 7); step();
         do_read_start(5);
      end
      ctl_clear(); load_b = 1; bwe = 0; byte_wr = '1; addr = AW'(6);
      data_in = pat(99, 3); step();
      do_read_start(6);
      do_desel(); do_desel();

      // Forced-read start ignores write controls (R4)
      cur_req = "R4";
      ctl_clear(); load_a = 1; gwe = 1; bwe = 1; byte_wr = '1;
      addr = AW'(9); data_in = pat(1, 15); step();
      do_read_start(9);
      do_desel(); do_desel();

      // Suspend repeats the beat; write burst in both orders (R3, R5)
      cur_req = "R3";
      do_read_start(13);
      do_adv(1'b0, '0);
      ctl_clear(); step();
      ctl_clear(); step();
      do_adv(1'b0, '0);
      for (int lin = 0; lin < 2; lin++) begin
         linear = lin[0];
         do_write_all(22, pat(22, 9 + lin));
         for (int k = 1; k < 4; k++) do_adv(1'b1, pat(22 + k, 9 + lin));
         do_read_start(20); do_adv(1'b0, '0); do_adv(1'b0, '0); do_adv(1'b0, '0);
      end
      linear = 1;
      do_desel(); do_desel();

      // Deselect right after a read, in both modes (R7, R8); write after read (R9)
      for (int s = 0; s < 2; s++) begin
         scd_mode = s[0];
         cur_req = s[0] ? "R7" : "R8";
         do_read_start(3);
         do_desel();
         do_desel();
         do_read_start(4); do_adv(1'b0, '0);
         do_desel(); do_desel(); do_desel();
         cur_req = "R9";
         do_read_start(3);
         do_write_all(40, pat(40, 4));
         do_write_all(41, pat(41, 4));
         do_desel(); do_desel();
      end
      scd_mode = 0;

      // Asynchronous output enable (R10)
      cur_req = "R10";
      do_read_start(7);
      do_adv(1'b0, '0);
      #1 oe = 0;
      #1 chk(data_drv == 1'b0, "R10", "async oe off", DW'(data_drv), '0);
      oe = 1;
      #1 chk(data_drv == 1'b1, "R10", "async oe on", DW'(data_drv), DW'(1));
      ctl_clear(); adv = 1; oe = 0; step();
      oe = 1;
      do_adv(1'b0, '0);
      do_desel(); do_desel();

      // Sleep: async drive-off, refused commands, contents kept (R11)
      cur_req = "R11";
      do_read_start(30);
      do_adv(1'b0, '0);
      #1 sleep = 1;
      #1 chk(data_drv == 1'b0, "R11", "async sleep off", DW'(data_drv), '0);
      sleep = 0;
      #1 chk(data_drv == 1'b1, "R11", "async sleep release", DW'(data_drv), DW'(1));
      sleep = 1;
      ctl_clear(); load_b = 1; gwe = 1; addr = AW'(30); data_in = pat(5, 12); step();
      ctl_clear(); adv = 1; gwe = 1; data_in = pat(6, 12); step();
      sleep = 0;
      ctl_clear(); adv = 1; step();
      ctl_clear(); adv = 1; step();
      do_read_start(30); do_adv(1'b0, '0);
      do_desel(); do_desel();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule